// File: doc/BRIEF.md
# Vertical die-to-die serial word link

This block moves 32-bit words from one die of a stack to the die below it over a narrow vertical bus. On the sending die, each accepted word is cut into four 8-bit beats and driven onto eight lanes. The sender also drives a marker line and forwards its own clock and reset next to the lanes. On the receiving die, the beats are captured on that forwarded clock and put back together into a word. The word is then written into a small dual-clock buffer. The receiver's logic reads words out of that buffer in its own clock domain.

The two dies run at the same nominal frequency, but the phase between their clocks is unknown. Every crossing between the two domains therefore uses Gray-coded pointers and two-flop synchronizers. When the receiving buffer is close to full, a flag is raised. That flag travels back across the stack and is synchronized on the sending die, where it stops the sender from accepting new words. Fewer vertical wires are needed, and the cost is four serial beats per word.

The top module contains both halves. The lane, clock, reset and return-flag wires appear as ports, so the stack wiring between the two dies sits outside the block.

Top module: `vlink_top`

## Requirements
- R1: Every accepted 32-bit word leaves the receive port once, intact and in acceptance order. It crosses the link as 4 beats on 8 lanes, and beat k carries bits [8k+7:8k].
- R2: The marker line is high only on the beat carrying bits [7:0], and that beat is on the lanes in the cycle after the word is accepted. On the other three beats, and while the link is idle, the marker is low.
- R3: No word is lost and the buffer is never written while full, even when the receive side holds rx_ready low for a long time.
- R4: For 3 cycles after a word is accepted, tx_ready is low. With a steady supply of words and free buffer space, one word is accepted every 4th cycle.
- R5: The 8-entry buffer raises its near-full flag once its write side counts at least 5 stored words. With rx_ready held low, the sender accepts between 5 and 7 words and then keeps tx_ready low.
- R6: After reset, tx_ready is 1, rx_valid is 0 and the marker is 0. rx_valid is high only while an accepted word has not yet been delivered.
- R7: While rx_valid is high and rx_ready is low, the next cycle still shows rx_valid high with the same rx_data.
- R8: After reset, and after a word is complete, the receiver ignores lane beats that come without the marker, and no word comes out.
- R9: A marker that arrives in the middle of a partial word throws the partial word away and starts a new word at bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sending die clock |
| tx_rst | input | 1 | Sending die synchronous reset, active high |
| tx_data | input | 32 | Word offered for sending |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Word is taken at this edge when tx_valid is high |
| ln_out_clk | output | 1 | Forwarded sender clock, driven down the stack |
| ln_out_rst | output | 1 | Forwarded sender reset |
| ln_out_data | output | 8 | Lane beat driven down the stack |
| ln_out_frame | output | 1 | Marker for the first beat of a word |
| ln_ret_full_in | input | 1 | Near-full flag returned from the receiving die |
| ln_in_clk | input | 1 | Forwarded clock arriving from above |
| ln_in_rst | input | 1 | Forwarded reset arriving from above |
| ln_in_data | input | 8 | Lane beat arriving from above |
| ln_in_frame | input | 1 | Marker arriving from above |
| ln_ret_full_out | output | 1 | Near-full flag sent back up, in the forwarded-clock domain |
| rx_clk | input | 1 | Receiving die clock |
| rx_rst | input | 1 | Receiving die synchronous reset, active high |
| rx_data | output | 32 | Delivered word |
| rx_valid | output | 1 | rx_data holds a word |
| rx_ready | input | 1 | Consumer takes the word at this edge |

## Verification
The hardest case to reach is the stall path: the returned near-full flag has to stop the sender before the in-flight words overrun the buffer. The bench reaches it by holding rx_ready low while it keeps offering words, and it checks that the accepted count stays within the margin. Misaligned and unframed beats never appear in normal operation. The bench creates them by switching the lane loopback to its own drivers and sending stray beats, a cut-off word and a marker in the middle of a word. In between, random backpressure on rx_ready drives the hold-stable rule and the Gray-pointer crossings at an arbitrary phase offset between the two clocks.

// File: rtl/vlink_pkg.sv
`timescale 1ns/1ps
package vlink_pkg;
    // Capture state of the receiving deserializer
    typedef enum logic {
        CAPT_IDLE = 1'b0,
        CAPT_BUSY = 1'b1
    } capt_mode_e;

    localparam int DEF_WORD_W = 32;
    localparam int DEF_LANES  = 8;
    localparam int DEF_AW     = 3;
    localparam int DEF_MARGIN = 3;
endpackage

// File: rtl/vlink_ser.sv
`timescale 1ns/1ps
module vlink_ser #(
    parameter int WORD_W = 32,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              back_full,
    output logic [LANES-1:0]  ln_data,
    output logic              ln_frame
);
    localparam int BEATS = WORD_W / LANES;
    localparam int CW    = $clog2(BEATS) + 1;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CW-1:0]     left;
        logic [LANES-1:0]  lane;
        logic              frame;
        logic              full_s1;
        logic              full_s2;
    } ser_t;

    ser_t ser_q, ser_d;

    assign in_ready = (ser_q.left == '0) && !ser_q.full_s2;
    assign ln_data  = ser_q.lane;
    assign ln_frame = ser_q.frame;

    always_comb begin
        ser_d         = ser_q;
        ser_d.full_s1 = back_full;
        ser_d.full_s2 = ser_q.full_s1;
        ser_d.frame   = 1'b0;
        if (in_valid && in_ready) begin
            ser_d.lane  = in_data[LANES-1:0];
            ser_d.shreg = in_data >> LANES;
            ser_d.left  = CW'(BEATS - 1);
            ser_d.frame = 1'b1;
        end else if (ser_q.left != '0) begin
            ser_d.lane  = ser_q.shreg[LANES-1:0];
            ser_d.shreg = ser_q.shreg >> LANES;
            ser_d.left  = ser_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ser_q <= '0;
        else     ser_q <= ser_d;
    end

    // R2: an accepted word shows its first beat, marked, on the next cycle
    p_marker_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ln_frame);

    generate
        if (BEATS > 1) begin : g_multi_beat
            // R2: a marker never sits on two beats in a row
            p_marker_single_r2: assert property (@(posedge clk) disable iff (rst)
                ln_frame |=> !ln_frame);
            // R4: no new word while the first beat is on the lanes
            p_busy_stall_r4: assert property (@(posedge clk) disable iff (rst)
                ln_frame |-> !in_ready);
        end
    endgenerate
endmodule

// File: rtl/vlink_deser.sv
`timescale 1ns/1ps
module vlink_deser
    import vlink_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  ln_data,
    input  logic              ln_frame,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_en
);
    localparam int BEATS = WORD_W / LANES;
    localparam int IW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        capt_mode_e        mode;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] word;
        logic              strobe;
    } des_t;

    des_t des_q, des_d;

    assign wr_word = des_q.word;
    assign wr_en   = des_q.strobe;

    always_comb begin
        des_d        = des_q;
        des_d.strobe = 1'b0;
        if (ln_frame) begin
            // marker always restarts a word, discarding any partial one
            des_d.acc[LANES-1:0] = ln_data;
            des_d.idx            = IW'(1);
            des_d.mode           = CAPT_BUSY;
        end else if (des_q.mode == CAPT_BUSY) begin
            des_d.acc[des_q.idx*LANES +: LANES] = ln_data;
            if (des_q.idx == IW'(BEATS - 1)) begin
                des_d.mode   = CAPT_IDLE;
                des_d.idx    = '0;
                des_d.word   = des_d.acc;
                des_d.strobe = 1'b1;
            end else begin
                des_d.idx = des_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) des_q <= '0;
        else     des_q <= des_d;
    end

    // R8: unmarked beats while idle never produce a word
    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (des_q.mode == CAPT_IDLE && !ln_frame) |=> !wr_en);

    generate
        if (BEATS > 1) begin : g_spacing
            // R8: words complete at most once per several beats
            p_strobe_spacing_r8: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> !wr_en);
        end
    endgenerate
endmodule

// File: rtl/vlink_afifo.sv
`timescale 1ns/1ps
module vlink_afifo #(
    parameter int W      = 32,
    parameter int AW     = 3,
    parameter int MARGIN = 3
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         near_full,
    input  logic         rclk,
    input  logic         rrst,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [PW-1:0] rg1;
        logic [PW-1:0] rg2;
        logic          nfull;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic [PW-1:0] wg1;
        logic [PW-1:0] wg2;
    } rside_t;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wside_t        ws_q, ws_d;
    rside_t        rs_q, rs_d;
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] used_w;
    logic          full_w;
    logic          push_w;
    logic          empty_r;
    logic          pop_r;

    // ---------------- write side (forwarded clock) ----------------
    always_comb begin
        ws_d       = ws_q;
        used_w     = ws_q.wbin - from_gray(ws_q.rg2);
        full_w     = (used_w == PW'(DEPTH));
        push_w     = wr_en && !full_w;
        ws_d.wbin  = ws_q.wbin + PW'(push_w);
        ws_d.wgray = to_gray(ws_d.wbin);
        ws_d.rg1   = rs_q.rgray;
        ws_d.rg2   = ws_q.rg1;
        ws_d.nfull = (used_w >= PW'(DEPTH - MARGIN));
    end

    always_ff @(posedge wclk) begin
        if (wrst) ws_q <= '0;
        else      ws_q <= ws_d;
    end

    always_ff @(posedge wclk) begin
        if (push_w) mem[ws_q.wbin[AW-1:0]] <= wr_data;
    end

    assign near_full = ws_q.nfull;

    // ---------------- read side (local clock) ----------------
    assign empty_r  = (rs_q.rgray == rs_q.wg2);
    assign rd_valid = !empty_r;
    assign pop_r    = rd_valid && rd_ready;
    assign rd_data  = mem[rs_q.rbin[AW-1:0]];

    always_comb begin
        rs_d       = rs_q;
        rs_d.rbin  = rs_q.rbin + PW'(pop_r);
        rs_d.rgray = to_gray(rs_d.rbin);
        rs_d.wg1   = ws_q.wgray;
        rs_d.wg2   = rs_q.wg1;
    end

    always_ff @(posedge rclk) begin
        if (rrst) rs_q <= '0;
        else      rs_q <= rs_d;
    end

    // R3: the stall margin keeps every completed word out of a full buffer
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (wrst)
        wr_en |-> !full_w);
    // R3: write pointer crosses with one bit changing per step
    p_wgray_step_r3: assert property (@(posedge wclk) disable iff (wrst)
        $countones(ws_q.wgray ^ $past(ws_q.wgray)) <= 1);
    // R6: read pointer crosses with one bit changing per step
    p_rgray_step_r6: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rs_q.rgray ^ $past(rs_q.rgray)) <= 1);
    // R7: a word waiting for the consumer stays put
    p_hold_word_r7: assert property (@(posedge rclk) disable iff (rrst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/vlink_top.sv
`timescale 1ns/1ps
module vlink_top #(
    parameter int WORD_W       = vlink_pkg::DEF_WORD_W,
    parameter int LANES        = vlink_pkg::DEF_LANES,
    parameter int FIFO_AW      = vlink_pkg::DEF_AW,
    parameter int STALL_MARGIN = vlink_pkg::DEF_MARGIN
) (
    input  logic              tx_clk,
    input  logic              tx_rst,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ln_out_clk,
    output logic              ln_out_rst,
    output logic [LANES-1:0]  ln_out_data,
    output logic              ln_out_frame,
    input  logic              ln_ret_full_in,
    input  logic              ln_in_clk,
    input  logic              ln_in_rst,
    input  logic [LANES-1:0]  ln_in_data,
    input  logic              ln_in_frame,
    output logic              ln_ret_full_out,
    input  logic              rx_clk,
    input  logic              rx_rst,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready
);
    logic [WORD_W-1:0] cap_word;
    logic              cap_en;

    assign ln_out_clk = tx_clk;
    assign ln_out_rst = tx_rst;

    vlink_ser #(.WORD_W(WORD_W), .LANES(LANES)) u_ser (
        .clk       (tx_clk),
        .rst       (tx_rst),
        .in_data   (tx_data),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .back_full (ln_ret_full_in),
        .ln_data   (ln_out_data),
        .ln_frame  (ln_out_frame)
    );

    vlink_deser #(.WORD_W(WORD_W), .LANES(LANES)) u_deser (
        .clk      (ln_in_clk),
        .rst      (ln_in_rst),
        .ln_data  (ln_in_data),
        .ln_frame (ln_in_frame),
        .wr_word  (cap_word),
        .wr_en    (cap_en)
    );

    vlink_afifo #(.W(WORD_W), .AW(FIFO_AW), .MARGIN(STALL_MARGIN)) u_fifo (
        .wclk      (ln_in_clk),
        .wrst      (ln_in_rst),
        .wr_en     (cap_en),
        .wr_data   (cap_word),
        .near_full (ln_ret_full_out),
        .rclk      (rx_clk),
        .rrst      (rx_rst),
        .rd_valid  (rx_valid),
        .rd_ready  (rx_ready),
        .rd_data   (rx_data)
    );
endmodule

// File: tb/vlink_top_bench.sv
`timescale 1ns/1ps
module vlink_top_bench;
    logic        tx_clk = 1'b0;
    logic        rx_clk = 1'b0;
    logic        tx_rst = 1'b1;
    logic        rx_rst = 1'b1;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        ln_out_clk, ln_out_rst, ln_out_frame, ret_full;
    logic [7:0]  ln_out_data;
    logic [7:0]  ln_in_data;
    logic        ln_in_frame;
    logic        inject = 1'b0;
    logic        inj_frame = 1'b0;
    logic [7:0]  inj_data = '0;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;

    assign ln_in_data  = inject ? inj_data  : ln_out_data;
    assign ln_in_frame = inject ? inj_frame : ln_out_frame;

    vlink_top u_vlink_top (
        .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .ln_out_clk(ln_out_clk), .ln_out_rst(ln_out_rst),
        .ln_out_data(ln_out_data), .ln_out_frame(ln_out_frame), .ln_ret_full_in(ret_full),
        .ln_in_clk(ln_out_clk), .ln_in_rst(ln_out_rst), .ln_in_data(ln_in_data),
        .ln_in_frame(ln_in_frame), .ln_ret_full_out(ret_full), .rx_clk(rx_clk),
        .rx_rst(rx_rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    // 200 MHz on both dies, receiver shifted by an odd phase
    always #2.5 tx_clk = ~tx_clk;
    initial begin
        #1.7;
        forever #2.5 rx_clk = ~rx_clk;
    end

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [31:0] to_send[$];
    logic [31:0] exp_rx[$];
    logic [8:0]  lane_exp[$];
    bit acc_pend = 1'b0;
    int last_acc = -1;
    bit strict_gap = 1'b0;
    int acc_count = 0;
    bit rdy_cfg = 1'b0;
    bit rnd_mode = 1'b0;
    logic [31:0] rseed = 32'h1234_5678;
    logic [31:0] dseed = 32'hCAFE_0001;
    bit prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // cycle counter and watchdog
    always @(posedge tx_clk) begin
        cyc++;
        if (cyc == 40000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=<40000", cyc);
            summary();
            $finish;
        end
    end

    // sender driver: inputs change 1 ns after the edge
    always @(posedge tx_clk) begin
        #1;
        if (acc_pend) begin
            to_send.delete(0);
            acc_pend = 1'b0;
        end
        if (to_send.size() > 0) begin
            tx_valid = 1'b1;
            tx_data  = to_send[0];
        end else begin
            tx_valid = 1'b0;
        end
    end

    // receiver ready driver
    always @(posedge rx_clk) begin
        #1;
        if (rnd_mode) begin
            rseed    = rseed * 32'd1103515245 + 32'd12345;
            rx_ready = rseed[16];
        end else begin
            rx_ready = rdy_cfg;
        end
    end

    // sender-side model, sampled mid-cycle
    always @(negedge tx_clk) begin
        logic [8:0] e;
        if (!tx_rst && !finished) begin
            if (lane_exp.size() > 0) begin
                e = lane_exp.pop_front();
                chk({ln_out_frame, ln_out_data} == e, "R2 lane beat",
                    32'({ln_out_frame, ln_out_data}), 32'(e));
            end else begin
                chk(ln_out_frame == 1'b0, "R2 idle marker", 32'(ln_out_frame), 32'd0);
            end
            if (lane_exp.size() > 0)
                chk(!tx_ready, "R4 stall mid-word", 32'(tx_ready), 32'd0);
            if (tx_valid && tx_ready) begin
                acc_pend = 1'b1;
                acc_count++;
                exp_rx.push_back(tx_data);
                for (int k = 0; k < 4; k++)
                    lane_exp.push_back({k == 0, tx_data[8*k +: 8]});
                if (last_acc >= 0)
                    chk(strict_gap ? (cyc - last_acc == 4) : (cyc - last_acc >= 4),
                        "R4 accept spacing", 32'(cyc - last_acc), 32'd4);
                last_acc = cyc;
            end
        end
    end

    // receiver-side model
    always @(negedge rx_clk) begin
        logic [31:0] w;
        if (!rx_rst && !finished) begin
            chk(!rx_valid || exp_rx.size() > 0, "R6 valid without word", 32'(rx_valid), 32'd0);
            if (prev_stall)
                chk(rx_valid && rx_data == prev_data, "R7 held word", rx_data, prev_data);
            if (rx_valid && rx_ready) begin
                if (exp_rx.size() > 0) begin
                    w = exp_rx.pop_front();
                    chk(rx_data == w, "R1 word", rx_data, w);
                end else begin
                    chk(1'b0, "R1 unexpected word", rx_data, 32'd0);
                end
            end
            prev_stall = rx_valid && !rx_ready;
            prev_data  = rx_data;
        end
    end

    function automatic logic [31:0] next_word();
        dseed = dseed * 32'd1664525 + 32'd1013904223;
        return dseed;
    endfunction

    task automatic drain(input string tag);
        for (int i = 0; i < 3000 && (to_send.size() != 0 || exp_rx.size() != 0); i++)
            @(posedge tx_clk);
        repeat (5) @(posedge tx_clk);
        chk(exp_rx.size() == 0 && to_send.size() == 0, tag, 32'(exp_rx.size()), 32'd0);
    endtask

    task automatic inj_beat(input logic f, input logic [7:0] d);
        @(posedge tx_clk);
        #1;
        inject    = 1'b1;
        inj_frame = f;
        inj_data  = d;
    endtask

    initial begin
        int acc0;
        logic [31:0] w;
        repeat (5) @(posedge tx_clk);
        #1;
        tx_rst = 1'b0;
        rx_rst = 1'b0;

        // R6: state after reset
        @(negedge tx_clk);
        chk(tx_ready == 1'b1, "R6 ready after reset", 32'(tx_ready), 32'd1);
        chk(ln_out_frame == 1'b0, "R6 marker after reset", 32'(ln_out_frame), 32'd0);
        @(negedge rx_clk);
        chk(rx_valid == 1'b0, "R6 no output after reset", 32'(rx_valid), 32'd0);

        // R1/R4: streaming with an always-ready consumer
        rdy_cfg = 1'b1;
        @(negedge tx_clk);
        last_acc   = -1;
        strict_gap = 1'b1;
        to_send.push_back(32'h0000_0000);
        to_send.push_back(32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) to_send.push_back(next_word());
        while (to_send.size() != 0) @(posedge tx_clk);
        @(negedge tx_clk);
        strict_gap = 1'b0;
        drain("R1 streamed words delivered");

        // R5/R3: consumer stalled, buffer fills and sender stops
        rdy_cfg = 1'b0;
        repeat (4) @(posedge tx_clk);
        acc0 = acc_count;
        @(negedge tx_clk);
        for (int i = 0; i < 12; i++) to_send.push_back(next_word());
        repeat (120) @(posedge tx_clk);
        @(negedge tx_clk);
        chk(acc_count - acc0 >= 5 && acc_count - acc0 <= 7, "R5 accepted before stall",
            32'(acc_count - acc0), 32'd7);
        chk(!tx_ready, "R5 sender stalled", 32'(tx_ready), 32'd0);
        @(negedge rx_clk);
        chk(rx_valid, "R3 words stored while stalled", 32'(rx_valid), 32'd1);
        rdy_cfg = 1'b1;
        drain("R3 no word lost after stall");

        // R7/R1: random consumer backpressure
        rnd_mode = 1'b1;
        @(negedge tx_clk);
        for (int i = 0; i < 24; i++) to_send.push_back(next_word());
        drain("R7 random backpressure drained");
        rnd_mode = 1'b0;
        repeat (4) @(posedge tx_clk);

        // R8: unmarked beats on an idle receiver
        for (int i = 0; i < 6; i++) inj_beat(1'b0, 8'h5A ^ 8'(i));
        inj_beat(1'b0, 8'h00);
        repeat (20) @(posedge tx_clk);
        @(negedge rx_clk);
        chk(rx_valid == 1'b0, "R8 stray beats ignored", 32'(rx_valid), 32'd0);

        // R9: marker inside a partial word restarts it
        w = 32'hC3A5_1E77;
        exp_rx.push_back(w);
        inj_beat(1'b1, 8'h11);
        inj_beat(1'b0, 8'h22);
        inj_beat(1'b1, w[7:0]);
        inj_beat(1'b0, w[15:8]);
        inj_beat(1'b0, w[23:16]);
        inj_beat(1'b0, w[31:24]);
        // R8: trailing unmarked beats after a finished word
        inj_beat(1'b0, 8'hEE);
        inj_beat(1'b0, 8'h33);
        inj_beat(1'b0, 8'h44);
        inj_beat(1'b0, 8'h00);
        drain("R9 only the restarted word delivered");
        repeat (20) @(posedge tx_clk);
        @(negedge rx_clk);
        chk(rx_valid == 1'b0, "R8 beats after word ignored", 32'(rx_valid), 32'd0);
        @(posedge tx_clk);
        #1;
        inject = 1'b0;

        // R1: link still works after the injected traffic
        @(negedge tx_clk);
        for (int i = 0; i < 4; i++) to_send.push_back(next_word());
        drain("R1 words after injection");

        summary();
        $finish;
    end
endmodule